// File: doc/BRIEF.md
# Multi-Group Clock Stop Controller

This block sits between a clock generator and the clock pins of a system board. It gates three groups of clocks: a processor group, a bus group and a serial-peripheral group. The bus clock is made inside the block by dividing the processor clock by two. The processor clock and the serial-peripheral clock arrive already generated.

Each group has its own active-high run input, and all groups share one active-low power-down input. These inputs may change at any time. Each one is synchronized in the clock domain it controls. The gating enable is then captured on the falling edge of the group clock and ANDed with that clock. A group therefore stops low and restarts on a full high phase. A parameter can mark chosen outputs as free-running: run inputs do not stop them, but power-down does.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output of every group is low.
- R2: A change on `proc_run` first affects the high phase that starts at the third rising edge of `proc_clk` after the change. `proc_run` low stops every processor output that is not free-running. `proc_run` high restores those outputs.
- R3: The internal bus clock has half the frequency of `proc_clk` and toggles on each rising edge of `proc_clk`. A running bus output is high for one `proc_clk` period and then low for one.
- R4: A change on `bus_run` first affects the high phase that starts at the third rising edge of the bus clock after the change. It acts only on bus outputs that are not free-running.
- R5: A change on `ser_run` first affects the high phase that starts at the third rising edge of `ser_clk` after the change. It acts on both serial outputs.
- R6: `FREE_MODE` selects which outputs are free-running:
  - `FREE_PROC_BUS` (2): `proc_ck[NPROC-1]`, `bus_ck[0]` and `bus_ck[1]`.
  - `FREE_BUS` (1): `bus_ck[0]` and `bus_ck[1]`.
  - `FREE_NONE` (0): no output.
- R7: When `pwr_n` goes low, every output stops, free-running outputs included. In each group the first missing high phase starts at the third rising edge of that group's clock.
- R8: When `pwr_n` goes high with its run input high, a free-running output resumes on the third rising edge of its clock. A gated output stays low through the fourth rising edge and resumes on the fifth.
- R9: An output is low whenever its clock is low. A stopped output stays low. No output ever shows a high pulse shorter than its clock's high phase.
- R10: Stopping or starting one group leaves the outputs of the other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled in each domain |
| proc_clk | input | 1 | Processor group source clock |
| ser_clk | input | 1 | Serial-peripheral group source clock |
| pwr_n | input | 1 | Asynchronous active-low power-down for all groups |
| proc_run | input | 1 | Asynchronous run request for the processor group |
| bus_run | input | 1 | Asynchronous run request for the bus group |
| ser_run | input | 1 | Asynchronous run request for the serial-peripheral group |
| proc_ck | output | NPROC | Gated processor clocks |
| bus_ck | output | NBUS | Gated bus clocks at half the processor rate |
| ser_ck | output | NSER | Gated serial-peripheral clocks |

## Verification
Every control input passes two synchronizer edges and then one falling-edge capture. Its result is therefore due on the high phase of the third rising edge of the controlled clock. After power-up, a gated output waits two more edges, so its result is due on the fifth. The directed tests change an input just after a falling edge of the controlled clock. They then sample the output two time units after each following rising edge. Results on the high phases before the due edge are checked as well as the due edge itself. The table rows wait long enough for all three groups to settle. Because the bench cannot see the bus clock's phase, each row samples the bus group on two consecutive processor edges and combines the samples.

// File: rtl/clkstop_pkg.sv
// Shared definitions for the clock stop controller.
// Assumes: free-running choices are fixed at elaboration time.
package clkstop_pkg;
    typedef enum logic [1:0] {
        FREE_NONE     = 2'd0,
        FREE_BUS      = 2'd1,
        FREE_PROC_BUS = 2'd2
    } free_mode_e;
endpackage

// File: rtl/clkstop_sync.sv
// Multi-flop synchronizer with a synchronous clear.
// Assumes: STAGES >= 2 and d is asynchronous to clk; a clear empties the whole chain.
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the chain; reset or clear empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
// Glitch-free clock gate bank: enables are captured while the clock is high
// (at its falling edge) and ANDed with the clock, so each change lands in a low phase.
// Assumes: pd_ok and run_ok are synchronous to clk; FREE marks outputs that ignore run_ok.
module clkstop_gate #(
    parameter int           N    = 2,
    parameter logic [N-1:0] FREE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_ok,
    input  logic         run_ok,
    output logic [N-1:0] en,
    output logic [N-1:0] ck
);
    for (genvar i = 0; i < N; i++) begin : g_out
        // Capture this output's enable on the falling clock edge.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                en[i] <= 1'b0;
            end else begin
                en[i] <= pd_ok && (run_ok || FREE[i]);
            end
        end

        assign ck[i] = clk & en[i];
    end
endmodule

// File: rtl/clkstop_domain.sv
// One clock group: synchronizes power-down and run, then drives the gate bank.
// Assumes: the run chain is held clear until power-down has been released in this
// domain, so gated outputs wait for a freshly synchronized run value.
module clkstop_domain #(
    parameter int           N      = 2,
    parameter int           STAGES = 2,
    parameter logic [N-1:0] FREE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_n,
    input  logic         run,
    output logic [N-1:0] ck,
    output logic [N-1:0] en,
    output logic         pd_ok,
    output logic         run_ok
);
    clkstop_sync #(.STAGES(STAGES)) i_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .d     (pwr_n),
        .q     (pd_ok)
    );

    clkstop_sync #(.STAGES(STAGES)) i_run_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pd_ok),
        .d     (run),
        .q     (run_ok)
    );

    clkstop_gate #(.N(N), .FREE(FREE)) i_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_ok  (pd_ok),
        .run_ok (run_ok),
        .en     (en),
        .ck     (ck)
    );
endmodule

// File: rtl/clkstop_ctrl.sv
// Clock stop controller top: divides the processor clock by two for the bus group
// and gates three clock groups under run and power-down control.
// Assumes: the divider phase is arbitrary at power-up; the bus domain is reset
// once the divider runs, which holds while rst_n is asserted for several cycles.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int         NPROC       = 7,
    parameter int         NBUS        = 10,
    parameter int         NSER        = 2,
    parameter int         SYNC_STAGES = 2,
    parameter free_mode_e FREE_MODE   = FREE_PROC_BUS
) (
    input  logic             rst_n,
    input  logic             proc_clk,
    input  logic             ser_clk,
    input  logic             pwr_n,
    input  logic             proc_run,
    input  logic             bus_run,
    input  logic             ser_run,
    output logic [NPROC-1:0] proc_ck,
    output logic [NBUS-1:0]  bus_ck,
    output logic [NSER-1:0]  ser_ck
);
    localparam logic [NPROC-1:0] PROC_FREE =
        (FREE_MODE == FREE_PROC_BUS) ? (NPROC'(1) << (NPROC - 1)) : '0;
    localparam logic [NBUS-1:0]  BUS_FREE  =
        (FREE_MODE == FREE_NONE) ? '0 : NBUS'(3);
    localparam logic [NSER-1:0]  SER_FREE  = '0;

    logic             bus_clk;
    logic [NPROC-1:0] proc_en;
    logic [NBUS-1:0]  bus_en;
    logic [NSER-1:0]  ser_en;
    logic             proc_pd_ok, proc_run_ok;
    logic             bus_pd_ok, bus_run_ok;
    logic             ser_pd_ok, ser_run_ok;

    // Toggle on every processor edge to form the half-rate bus clock.
    always_ff @(posedge proc_clk) begin
        bus_clk <= !bus_clk;
    end

    clkstop_domain #(.N(NPROC), .STAGES(SYNC_STAGES), .FREE(PROC_FREE)) i_proc (
        .clk (proc_clk), .rst_n (rst_n), .pwr_n (pwr_n), .run (proc_run),
        .ck (proc_ck), .en (proc_en), .pd_ok (proc_pd_ok), .run_ok (proc_run_ok)
    );

    clkstop_domain #(.N(NBUS), .STAGES(SYNC_STAGES), .FREE(BUS_FREE)) i_bus (
        .clk (bus_clk), .rst_n (rst_n), .pwr_n (pwr_n), .run (bus_run),
        .ck (bus_ck), .en (bus_en), .pd_ok (bus_pd_ok), .run_ok (bus_run_ok)
    );

    clkstop_domain #(.N(NSER), .STAGES(SYNC_STAGES), .FREE(SER_FREE)) i_ser (
        .clk (ser_clk), .rst_n (rst_n), .pwr_n (pwr_n), .run (ser_run),
        .ck (ser_ck), .en (ser_en), .pd_ok (ser_pd_ok), .run_ok (ser_run_ok)
    );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
// Checker for the clock stop controller: low-phase silence, power-down and run
// enables, free-running exemption. Attached to every clkstop_ctrl by bind.
module clkstop_ctrl_chk #(
    parameter int               NPROC     = 7,
    parameter int               NBUS      = 10,
    parameter int               NSER      = 2,
    parameter logic [NPROC-1:0] PROC_FREE = '0
) (
    input logic             rst_n,
    input logic             proc_clk,
    input logic             bus_clk,
    input logic             ser_clk,
    input logic [NPROC-1:0] proc_ck,
    input logic [NBUS-1:0]  bus_ck,
    input logic [NSER-1:0]  ser_ck,
    input logic [NPROC-1:0] proc_en,
    input logic [NBUS-1:0]  bus_en,
    input logic [NSER-1:0]  ser_en,
    input logic             proc_pd_ok,
    input logic             proc_run_ok,
    input logic             bus_pd_ok,
    input logic             bus_run_ok,
    input logic             ser_pd_ok,
    input logic             ser_run_ok
);
    AST_PROC_LOW_PHASE: assert property (@(posedge proc_clk) disable iff (!rst_n)
        proc_ck == '0); // R9
    AST_BUS_LOW_PHASE: assert property (@(posedge bus_clk) disable iff (!rst_n)
        bus_ck == '0); // R9
    AST_SER_LOW_PHASE: assert property (@(posedge ser_clk) disable iff (!rst_n)
        ser_ck == '0); // R9
    AST_PROC_PD_OFF: assert property (@(negedge proc_clk) disable iff (!rst_n)
        !proc_pd_ok |=> proc_en == '0); // R7
    AST_SER_PD_OFF: assert property (@(negedge ser_clk) disable iff (!rst_n)
        !ser_pd_ok |=> ser_en == '0); // R7
    AST_PROC_RUN_ON: assert property (@(negedge proc_clk) disable iff (!rst_n)
        (proc_pd_ok && proc_run_ok) |=> &proc_en); // R2
    AST_BUS_RUN_ON: assert property (@(negedge bus_clk) disable iff (!rst_n)
        (bus_pd_ok && bus_run_ok) |=> &bus_en); // R4
    AST_SER_RUN_ON: assert property (@(negedge ser_clk) disable iff (!rst_n)
        (ser_pd_ok && ser_run_ok) |=> &ser_en); // R5
    AST_PROC_FREE_KEPT: assert property (@(negedge proc_clk) disable iff (!rst_n)
        proc_pd_ok |=> (proc_en & PROC_FREE) == PROC_FREE); // R6
    AST_BUS_PD_OFF: assert property (@(negedge bus_clk) disable iff (!rst_n)
        !bus_pd_ok |=> bus_en == '0); // R7
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .NPROC (NPROC), .NBUS (NBUS), .NSER (NSER), .PROC_FREE (PROC_FREE)
) i_chk (
    .rst_n (rst_n), .proc_clk (proc_clk), .bus_clk (bus_clk), .ser_clk (ser_clk),
    .proc_ck (proc_ck), .bus_ck (bus_ck), .ser_ck (ser_ck),
    .proc_en (proc_en), .bus_en (bus_en), .ser_en (ser_en),
    .proc_pd_ok (proc_pd_ok), .proc_run_ok (proc_run_ok),
    .bus_pd_ok (bus_pd_ok), .bus_run_ok (bus_run_ok),
    .ser_pd_ok (ser_pd_ok), .ser_run_ok (ser_run_ok)
);

// File: tb/test_clkstop_ctrl.sv
module test_clkstop_ctrl;
    import clkstop_pkg::*;

    localparam int PERIOD     = 10;
    localparam int SER_PERIOD = 14;
    localparam int NPROC = 7;
    localparam int NBUS  = 10;
    localparam int NSER  = 2;

    // pwr_n, proc_run, bus_run, ser_run, expected proc, bus, ser masks (mode FREE_PROC_BUS)
    typedef struct packed {
        logic             pw;
        logic             pr;
        logic             br;
        logic             sr;
        logic [NPROC-1:0] ep;
        logic [NBUS-1:0]  eb;
        logic [NSER-1:0]  es;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 1'b1, 1'b1, 7'h7F, 10'h3FF, 2'h3},
        '{1'b1, 1'b0, 1'b1, 1'b1, 7'h40, 10'h3FF, 2'h3},
        '{1'b1, 1'b1, 1'b0, 1'b1, 7'h7F, 10'h003, 2'h3},
        '{1'b1, 1'b1, 1'b1, 1'b0, 7'h7F, 10'h3FF, 2'h0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 7'h40, 10'h003, 2'h0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 7'h00, 10'h000, 2'h0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 7'h7F, 10'h3FF, 2'h3}
    };

    logic rst_n = 1'b0;
    logic proc_clk = 1'b0;
    logic ser_clk = 1'b0;
    logic pwr_n = 1'b1;
    logic proc_run = 1'b1;
    logic bus_run = 1'b1;
    logic ser_run = 1'b1;
    logic [NPROC-1:0] proc_a, proc_b, proc_c;
    logic [NBUS-1:0]  bus_a, bus_b, bus_c;
    logic [NSER-1:0]  ser_a, ser_b, ser_c;
    logic [NBUS-1:0]  sb_a, sb_b, sb_c;
    int checks = 0;
    int errors = 0;
    logic s0, s1;

    always #(PERIOD/2) proc_clk = !proc_clk;
    always #(SER_PERIOD/2) ser_clk = !ser_clk;

    clkstop_ctrl #(.FREE_MODE(FREE_PROC_BUS)) i_clkstop_ctrl (
        .rst_n (rst_n), .proc_clk (proc_clk), .ser_clk (ser_clk), .pwr_n (pwr_n),
        .proc_run (proc_run), .bus_run (bus_run), .ser_run (ser_run),
        .proc_ck (proc_a), .bus_ck (bus_a), .ser_ck (ser_a)
    );
    clkstop_ctrl #(.FREE_MODE(FREE_BUS)) i_mode_bus (
        .rst_n (rst_n), .proc_clk (proc_clk), .ser_clk (ser_clk), .pwr_n (pwr_n),
        .proc_run (proc_run), .bus_run (bus_run), .ser_run (ser_run),
        .proc_ck (proc_b), .bus_ck (bus_b), .ser_ck (ser_b)
    );
    clkstop_ctrl #(.FREE_MODE(FREE_NONE)) i_mode_none (
        .rst_n (rst_n), .proc_clk (proc_clk), .ser_clk (ser_clk), .pwr_n (pwr_n),
        .proc_run (proc_run), .bus_run (bus_run), .ser_run (ser_run),
        .proc_ck (proc_c), .bus_ck (bus_c), .ser_ck (ser_c)
    );

    // Compare one result and log a failure line.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus phase is unknown to the bench: OR two consecutive processor-edge samples.
    task automatic sample_bus();
        @(posedge proc_clk); #2;
        sb_a = bus_a; sb_b = bus_b; sb_c = bus_c;
        @(posedge proc_clk); #2;
        sb_a |= bus_a; sb_b |= bus_b; sb_c |= bus_c;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs low throughout reset
        repeat (4) @(posedge proc_clk);
        #2;
        check("R1 proc", 32'(proc_a), 0);
        @(posedge ser_clk); #2;
        check("R1 ser", 32'(ser_a), 0);
        sample_bus();
        check("R1 bus", 32'(sb_a), 0);
        repeat (8) @(posedge proc_clk);
        @(negedge proc_clk);
        rst_n = 1'b1;
        repeat (20) @(posedge proc_clk);

        // Table walk: R2 R4 R5 R7 R10 under mixed run patterns
        for (int v = 0; v < NVEC; v++) begin
            @(negedge proc_clk);
            pwr_n = VECS[v].pw; proc_run = VECS[v].pr;
            bus_run = VECS[v].br; ser_run = VECS[v].sr;
            repeat (24) @(posedge proc_clk);
            #2;
            check($sformatf("R2/R7/R10 proc row %0d", v), 32'(proc_a), 32'(VECS[v].ep));
            sample_bus();
            check($sformatf("R4/R7/R10 bus row %0d", v), 32'(sb_a), 32'(VECS[v].eb));
            @(posedge ser_clk); #2;
            check($sformatf("R5/R7/R10 ser row %0d", v), 32'(ser_a), 32'(VECS[v].es));
        end

        // R3: bus clock alternates on successive processor edges
        @(posedge proc_clk); #2; s0 = bus_a[0];
        @(posedge proc_clk); #2; s1 = bus_a[0];
        check("R3 alternate", 32'(s0 ^ s1), 1);
        @(posedge proc_clk); #2;
        check("R3 period", 32'(bus_a[0]), 32'(s0));

        // R2: stop and restart latency in the processor group
        @(negedge proc_clk); proc_run = 1'b0;
        @(posedge proc_clk); #2; check("R2 stop e1", 32'(proc_a[0]), 1);
        @(posedge proc_clk); #2; check("R2 stop e2", 32'(proc_a[0]), 1);
        @(posedge proc_clk); #2; check("R2 stop e3", 32'(proc_a), 32'h40);
        @(negedge proc_clk); proc_run = 1'b1;
        @(posedge proc_clk); #2; check("R2 start e1", 32'(proc_a[0]), 0);
        @(posedge proc_clk); #2; check("R2 start e2", 32'(proc_a[0]), 0);
        @(posedge proc_clk); #2; check("R2 start e3", 32'(proc_a), 32'h7F);

        // R4: bus group latency, counted on free-running bus_ck[0]
        @(negedge bus_a[0]); #1; bus_run = 1'b0;
        @(posedge bus_a[0]); #2; check("R4 stop e1", 32'(bus_a[5]), 1);
        @(posedge bus_a[0]); #2; check("R4 stop e2", 32'(bus_a[5]), 1);
        @(posedge bus_a[0]); #2; check("R4 stop e3", 32'(bus_a), 32'h003);
        @(negedge bus_a[0]); #1; bus_run = 1'b1;
        @(posedge bus_a[0]); #2; check("R4 start e2", 32'(bus_a[5]), 0);
        @(posedge bus_a[0]); #2; check("R4 start e2", 32'(bus_a[5]), 0);
        @(posedge bus_a[0]); #2; check("R4 start e3", 32'(bus_a), 32'h3FF);

        // R5: serial group latency
        @(negedge ser_clk); ser_run = 1'b0;
        @(posedge ser_clk); #2; check("R5 stop e1", 32'(ser_a), 3);
        @(posedge ser_clk); #2; check("R5 stop e2", 32'(ser_a), 3);
        @(posedge ser_clk); #2; check("R5 stop e3", 32'(ser_a), 0);
        @(negedge ser_clk); ser_run = 1'b1;
        @(posedge ser_clk); #2; check("R5 start e2", 32'(ser_a), 0);
        @(posedge ser_clk); #2; check("R5 start e2", 32'(ser_a), 0);
        @(posedge ser_clk); #2; check("R5 start e3", 32'(ser_a), 3);

        // R7: power-down stops the free processor output on the third edge
        @(negedge proc_clk); pwr_n = 1'b0;
        @(posedge proc_clk); #2; check("R7 free e1", 32'(proc_a[6]), 1);
        @(posedge proc_clk); #2; check("R7 free e2", 32'(proc_a[6]), 1);
        @(posedge proc_clk); #2; check("R7 free e3", 32'(proc_a), 0);
        repeat (20) @(posedge proc_clk);

        // R8: free output returns on edge 3, gated outputs on edge 5
        @(negedge proc_clk); pwr_n = 1'b1;
        @(posedge proc_clk); #2; check("R8 e1", 32'(proc_a), 0);
        @(posedge proc_clk); #2; check("R8 e2", 32'(proc_a), 0);
        @(posedge proc_clk); #2; check("R8 e3", 32'(proc_a), 32'h40);
        @(posedge proc_clk); #2; check("R8 e4", 32'(proc_a), 32'h40);
        @(posedge proc_clk); #2; check("R8 e5", 32'(proc_a), 32'h7F);
        repeat (20) @(posedge proc_clk);

        // R6: free-running selection per mode, all runs low
        @(negedge proc_clk);
        proc_run = 1'b0; bus_run = 1'b0; ser_run = 1'b0;
        repeat (24) @(posedge proc_clk);
        #2;
        check("R6 proc mode2", 32'(proc_a), 32'h40);
        check("R6 proc mode1", 32'(proc_b), 0);
        check("R6 proc mode0", 32'(proc_c), 0);
        sample_bus();
        check("R6 bus mode2", 32'(sb_a), 32'h003);
        check("R6 bus mode1", 32'(sb_b), 32'h003);
        check("R6 bus mode0", 32'(sb_c), 0);

        finish_run();
    end
endmodule